// File: doc/BRIEF.md
# Timer interrupt flag and mask unit

This block holds the pending-event flags and the enable mask for two timer/counters that share one interrupt controller slice. The first timer reports overflow and two compare events. The second reports overflow, two compare events and an input-capture event. Each event arrives as a one-cycle pulse and latches a flag. A flag stays set until software writes a one to it or until the interrupt controller acknowledges the matching vector.

Both registers use the same 8-bit layout, because the vector priority encoder downstream decodes it:

| Bit | Source |
|-----|--------|
| 7 | timer1 overflow |
| 6 | timer1 compare A |
| 5 | timer1 compare B |
| 4 | reserved |
| 3 | timer1 input capture |
| 2 | timer0 compare B |
| 1 | timer0 overflow |
| 0 | timer0 compare A |

The block gates each flag with its mask bit and with the global interrupt enable, which lives outside the block. It drives one request per source and an OR of all requests. A single-bit register select chooses the register: 0 selects the mask and 1 selects the flags. Reads are combinational.

The timer0 overflow event is also qualified by `t0_ovf_ok`. The timer's waveform mode decides whether an overflow counts as an event, and this input carries that decision.

Top module: `tmr_irq_ctl`

## Requirements
- R1: After reset, both registers read 0x00, and `irq` and `irq_any` are 0.
- R2: An event pulse on `evt[i]` sets flag bit i at the next clock edge, for i in {0,2,3,5,6,7}.
- R3: Writing the flag register (`reg_sel`=1) clears every flag whose `reg_wdata` bit is 1. Flags whose `reg_wdata` bit is 0 keep their value.
- R4: When `ack[i]` is 1 at a clock edge, flag bit i is cleared.
- R5: If a set event and a clear (write-one or acknowledge) reach the same flag in the same cycle, the flag ends up set.
- R6: Writing the mask register (`reg_sel`=0) replaces the stored mask with `reg_wdata` on all implemented bits.
- R7: `irq[i]` is 1 exactly when `gie`, mask bit i and flag bit i are all 1. `irq_any` is the OR of all `irq` bits.
- R8: Bit 4 of both registers always reads 0. Writes and events on bit 4 have no effect, and `irq[4]` is always 0.
- R9: An event on `evt[1]` (timer0 overflow) sets flag bit 1 only when `t0_ovf_ok` is 1 in the same cycle.
- R10: `reg_rdata` shows the selected register's current contents in the same cycle, without a clock delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_sel | input | 1 | Register select: 0 selects the mask, 1 selects the flags |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register |
| evt | input | 8 | Per-source event pulses, using the bit layout above |
| t0_ovf_ok | input | 1 | Qualifier for the timer0 overflow event |
| ack | input | 8 | Per-source vector acknowledge |
| gie | input | 1 | Global interrupt enable |
| irq | output | 8 | Gated request for each source |
| irq_any | output | 1 | OR of all gated requests |

## Verification
Single-bit event and acknowledge walks show that each flag is wired to its own source and its own clear path, and that bit 4 stays dead. Writing all 256 mask values over a full flag set, with the global enable both off and on, tells the three-input gating apart from a two-input gate or a mis-routed bit. Same-cycle collisions separate set-wins from clear-wins. Writing zero to the flag register separates write-one-to-clear from a plain overwrite. A long pseudo-random run mixes writes, events, acknowledges and qualifier changes, and compares both registers and all requests against a model built from the requirements.

// File: rtl/tmr_irq_ctl.sv
`timescale 1ns/1ps
module tmr_irq_ctl #(
  parameter int          W        = 8,
  parameter logic [W-1:0] IMPL    = 8'hEF,
  parameter int          T0_OVF_BIT = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         reg_sel,
  input  logic         reg_wr,
  input  logic [W-1:0] reg_wdata,
  output logic [W-1:0] reg_rdata,
  input  logic [W-1:0] evt,
  input  logic         t0_ovf_ok,
  input  logic [W-1:0] ack,
  input  logic         gie,
  output logic [W-1:0] irq,
  output logic         irq_any
);
  localparam logic [W-1:0] QUAL = W'(1) << T0_OVF_BIT;

  logic [W-1:0] mask_q, flag_q;
  logic [W-1:0] set_v, clr_v;

  assign set_v = evt & IMPL & ~(QUAL & {W{~t0_ovf_ok}});
  assign clr_v = ack | ((reg_wr && reg_sel) ? reg_wdata : '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= '0;
      flag_q <= '0;
    end else begin
      flag_q <= ((flag_q & ~clr_v) | set_v) & IMPL;
      if (reg_wr && !reg_sel)
        mask_q <= reg_wdata & IMPL;
    end
  end

  assign reg_rdata = reg_sel ? flag_q : mask_q;
  assign irq       = {W{gie}} & mask_q & flag_q;
  assign irq_any   = |irq;
endmodule

module tmr_irq_ctl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_sel,
  input logic       reg_wr,
  input logic [7:0] reg_wdata,
  input logic [7:0] reg_rdata,
  input logic [7:0] evt,
  input logic       t0_ovf_ok,
  input logic [7:0] ack,
  input logic       gie,
  input logic [7:0] irq,
  input logic       irq_any,
  input logic [7:0] flag
);
  p_evt_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flag & $past(evt & 8'hED)) == $past(evt & 8'hED)));

  p_w0_keeps_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_sel && reg_wdata == 8'h00 && ack == 8'h00 && evt == 8'h00) |=> $stable(flag));

  p_ack_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flag & $past(ack & ~evt)) == 8'h00));

  p_no_gie_no_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !gie |-> (irq == 8'h00 && !irq_any));

  p_rsv_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[4] == 1'b0) && (irq[4] == 1'b0));

  p_t0_qual_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!t0_ovf_ok && !flag[1]) |=> !flag[1]);
endmodule

bind tmr_irq_ctl tmr_irq_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt(evt),
  .t0_ovf_ok(t0_ovf_ok), .ack(ack), .gie(gie), .irq(irq),
  .irq_any(irq_any), .flag(flag_q)
);

// File: tb/tmr_irq_ctl_bench.sv
`timescale 1ns/1ps
module tmr_irq_ctl_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       reg_sel, reg_wr, t0_ovf_ok, gie;
  logic [7:0] reg_wdata, evt, ack;
  logic [7:0] reg_rdata, irq;
  logic       irq_any;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] m_flag = 8'h00;
  logic [7:0] m_mask = 8'h00;

  always #2.5 clk = ~clk;

  tmr_irq_ctl u_tmr_irq_ctl (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt(evt),
    .t0_ovf_ok(t0_ovf_ok), .ack(ack), .gie(gie), .irq(irq), .irq_any(irq_any)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic idle();
    reg_wr = 1'b0; evt = 8'h00; ack = 8'h00; reg_wdata = 8'h00;
  endtask

  task automatic tick();
    logic [7:0] s, c;
    @(posedge clk);
    s = evt & 8'hED;
    if (t0_ovf_ok) s = s | (evt & 8'h02);
    c = ack;
    if (reg_wr && reg_sel) c = c | reg_wdata;
    m_flag = ((m_flag & ~c) | s) & 8'hEF;
    if (reg_wr && !reg_sel) m_mask = reg_wdata & 8'hEF;
    @(negedge clk);
    idle();
  endtask

  task automatic read_all(input string tag);
    reg_sel = 1'b1; #0.5;
    check({tag, " flags"}, reg_rdata, m_flag);
    reg_sel = 1'b0; #0.5;
    check({tag, " mask"}, reg_rdata, m_mask);
    check({tag, " irq"}, irq, gie ? (m_mask & m_flag) : 8'h00);
    check({tag, " irq_any"}, {7'd0, irq_any}, {7'd0, gie && ((m_mask & m_flag) != 8'h00)});
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    reg_sel = sel; reg_wr = 1'b1; reg_wdata = d; tick();
  endtask

  initial begin
    #(5.0 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] lfsr;
    rst_n = 1'b0; reg_sel = 1'b0; t0_ovf_ok = 1'b1; gie = 1'b0;
    idle();
    evt = 8'hFF;
    repeat (3) @(negedge clk);
    idle();
    read_all("R1 reset");
    rst_n = 1'b1;

    for (int i = 0; i < 8; i++) begin
      evt = 8'(1 << i); tick();
      reg_sel = 1'b1; #0.5;
      check(i == 4 ? "R8 event on reserved bit" : "R2 event sets flag", reg_rdata, 8'(1 << i) & 8'hEF);
      wr(1'b1, 8'(1 << i));
      reg_sel = 1'b1; #0.5;
      check("R3 write one clears", reg_rdata, 8'h00);
    end

    evt = 8'hFF; tick();
    wr(1'b1, 8'h00);
    reg_sel = 1'b1; #0.5;
    check("R3 write zero keeps", reg_rdata, 8'hEF);
    wr(1'b1, 8'h5A);
    reg_sel = 1'b1; #0.5;
    check("R3 partial clear", reg_rdata, 8'hA5);

    evt = 8'hFF; tick();
    for (int i = 0; i < 8; i++) begin
      ack = 8'(1 << i); tick();
      reg_sel = 1'b1; #0.5;
      check("R4 ack clears one bit", reg_rdata, 8'hEF & ~(8'hFF >> (7 - i)));
    end

    evt = 8'hFF; ack = 8'hFF; tick();
    reg_sel = 1'b1; #0.5;
    check("R5 event beats ack", reg_rdata, 8'hEF);
    evt = 8'h81; reg_sel = 1'b1; reg_wr = 1'b1; reg_wdata = 8'hFF; tick();
    reg_sel = 1'b1; #0.5;
    check("R5 event beats write one", reg_rdata, 8'h81);

    wr(1'b0, 8'hAA);
    wr(1'b0, 8'h55);
    reg_sel = 1'b0; #0.5;
    check("R6 mask replaced, R8 bit4 dropped", reg_rdata, 8'h45);
    wr(1'b0, 8'h10);
    reg_sel = 1'b0; #0.5;
    check("R8 mask bit4 ignored", reg_rdata, 8'h00);

    wr(1'b1, 8'hFF);
    t0_ovf_ok = 1'b0; evt = 8'h02; tick();
    reg_sel = 1'b1; #0.5;
    check("R9 overflow blocked", reg_rdata, 8'h00);
    t0_ovf_ok = 1'b1; evt = 8'h02; tick();
    reg_sel = 1'b1; #0.5;
    check("R9 overflow passed", reg_rdata, 8'h02);

    evt = 8'hFF; tick();
    for (int g = 0; g < 2; g++) begin
      gie = g[0];
      for (int m = 0; m < 256; m++) begin
        reg_sel = 1'b0; reg_wr = 1'b1; reg_wdata = 8'(m); #0.5;
        check("R10 read before write lands", reg_rdata, m_mask);
        tick();
        reg_sel = 1'b0; #0.5;
        check("R7 irq gating", irq, gie ? (8'(m) & 8'hEF) : 8'h00);
        check("R7 irq_any", {7'd0, irq_any}, {7'd0, gie && ((8'(m) & 8'hEF) != 8'h00)});
      end
    end

    lfsr = 32'h1ACE_B00C;
    for (int k = 0; k < 4000; k++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      evt = lfsr[7:0] & lfsr[15:8];
      ack = lfsr[23:16] & lfsr[31:24] & lfsr[7:0];
      reg_wr = lfsr[9] & lfsr[3];
      reg_sel = lfsr[12];
      reg_wdata = lfsr[27:20];
      t0_ovf_ok = lfsr[5];
      gie = lfsr[17] | lfsr[29];
      tick();
      if (k % 4 == 0) read_all("R7 random mix");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule